// File: doc/BRIEF.md
# Machine-Check Bank Error Logger

This block keeps the error record of a small machine-check unit. It holds a capability word, a global control word, a global status word and a parameterised set of banks. Each bank has four 64-bit words: control, status, address and misc. Software reads and writes every word through an indexed register port. A separate injection port delivers one error report per cycle. A report carries a bank number, a bank status, a new global status, an address, a misc word and an unconditional flag.

Each report is judged against the current state. It is rejected when it is malformed. It is ignored when it would nest inside a machine check already in progress. It is dropped when reporting is disabled. It escalates to a reset request when it cannot be delivered. Otherwise it is logged, with overflow marking when the bank already held a valid record. The outcome appears as a result code one cycle after the report. A logged uncorrected error also gives a one-cycle interrupt pulse, and an escalation gives a one-cycle reset-request pulse.

Top module: `mcb_logger`

## Requirements
- R1: After a synchronous active-low reset, the capability word reads NBANK with bit 8 (control present) set. Global control and every bank control read all ones. Global status and every bank status, address and misc word read zero. `res_valid`, `mc_irq` and `reset_req` are low.
- R2: Register index map: 0 capability, 1 global control, 2 global status, index 3 unmapped. Bank b word k sits at 4 + 4*b + k, with k = 0 control, 1 status, 2 address, 3 misc. Reads are combinational. A write is visible on the next cycle. Unmapped indices read zero and ignore writes.
- R3: A report gets code 1 (reject) and changes no state when any of these holds: the capability word is zero, the bank number is not below capability bits 7:0, the bank number is not below NBANK, or status bit 63 (valid) is clear.
- R4: A report with global status bit 2 (in progress) set, status bit 55 (action required) clear and the unconditional flag low gets code 2 (ignore) and changes no state.
- R5: An uncorrected report (status bit 61) gets code 3 (disabled) and changes no state when either of these holds: capability bit 8 is set and global control is not all ones, or the bank control is not all ones.
- R6: An uncorrected report that is not disabled gets code 5 and pulses `reset_req` for one cycle, with no state change, when `mc_enable` is low or global status bit 2 is set.
- R7: An uncorrected report that is logged gets code 4. It writes the bank address and misc and the global status. The bank status becomes the reported status, with bit 62 (overflow) also set if the old bank status had bit 63. `mc_irq` pulses for one cycle.
- R8: A corrected report whose bank's old status is not valid, or valid but not uncorrected, gets code 4. It overwrites status, address and misc, setting bit 62 if the old status was valid. Global status is left untouched and `mc_irq` stays low.
- R9: A corrected report on a bank that holds a valid uncorrected status gets code 4. It only sets bit 62 of the existing status and leaves address and misc unchanged.
- R10: `res_valid`, `res_code`, `mc_irq` and `reset_req` are registered and appear exactly one cycle after the report's clock edge. Back-to-back reports each get their own result. A register write in the same cycle as a report is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_enable | input | 1 | Machine-check delivery enabled by the core |
| inj_valid | input | 1 | Error report present this cycle |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Reported bank status |
| inj_gstatus | input | 64 | Global status to load on an uncorrected log |
| inj_addr | input | 64 | Reported address |
| inj_misc | input | 64 | Reported misc word |
| inj_force | input | 1 | Unconditional: bypass the nesting-ignore rule |
| reg_idx | input | IW | Register index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| res_valid | output | 1 | Result present (one-cycle pulse) |
| res_code | output | 3 | 1 reject, 2 ignore, 3 disabled, 4 logged, 5 reset |
| mc_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset request pulse |

## Verification
A report driven before clock edge E has its result code and its pulses present during the cycle after E. Its effect on the register file is readable combinationally from that same cycle. The bench drives inputs just after a rising edge. A behavioural model updates on each rising edge from those stable inputs and records the expected pulses. The design's outputs and the read data for the current index are compared with the model on the following falling edge, so each comparison lands in the cycle where the result is due. A register write appears in reads from the cycle after its strobe, and the model applies it on the same edge.

// File: rtl/mcb_pkg.sv
// Shared constants and types for the machine-check bank logger.
// Assumes 64-bit registers and the architectural status bit layout.
package mcb_pkg;
    localparam int XLEN     = 64;
    localparam int ST_VAL   = 63;
    localparam int ST_OVER  = 62;
    localparam int ST_UC    = 61;
    localparam int ST_AR    = 55;
    localparam int GS_MCIP  = 2;
    localparam int CAP_CTLP = 8;
    localparam int CAP_NBW  = 8;

    typedef enum logic [2:0] {
        RC_NONE     = 3'd0,
        RC_REJECT   = 3'd1,
        RC_IGNORE   = 3'd2,
        RC_DISABLED = 3'd3,
        RC_LOGGED   = 3'd4,
        RC_RESET    = 3'd5
    } mcb_rc_e;

    typedef struct packed {
        logic [XLEN-1:0] ctl;
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] misc;
    } mcb_bank_t;
endpackage

// File: rtl/mcb_judge.sv
// Combinational decision for one error report.
// Produces the result code and the write enables for bank and global state.
// Assumes the caller supplies the selected bank's control and status
// (zero when the bank number is beyond NBANK) and a range flag.
module mcb_judge
    import mcb_pkg::*;
(
    input  logic            req,
    input  logic            bank_ok,
    input  logic [7:0]      inj_bank,
    input  logic [XLEN-1:0] inj_status,
    input  logic            inj_force,
    input  logic            mc_enable,
    input  logic [XLEN-1:0] cap,
    input  logic [XLEN-1:0] gctl,
    input  logic [XLEN-1:0] gst,
    input  logic [XLEN-1:0] old_ctl,
    input  logic [XLEN-1:0] old_status,
    output mcb_rc_e         code,
    output logic            st_we,
    output logic            am_we,
    output logic            gs_we,
    output logic [XLEN-1:0] new_status
);
    logic nested, uc, old_val, blocked;

    assign nested  = gst[GS_MCIP];
    assign uc      = inj_status[ST_UC];
    assign old_val = old_status[ST_VAL];
    assign blocked = (cap[CAP_CTLP] && (gctl != '1)) || (old_ctl != '1);

    // Rule chain: reject, ignore, disable, escalate, then log.
    always_comb begin
        code       = RC_NONE;
        st_we      = 1'b0;
        am_we      = 1'b0;
        gs_we      = 1'b0;
        new_status = old_status;
        if (!req) begin
            code = RC_NONE;
        end else if ((cap == '0) || !bank_ok || (inj_bank >= cap[CAP_NBW-1:0])
                     || !inj_status[ST_VAL]) begin
            code = RC_REJECT;
        end else if (!inj_force && !inj_status[ST_AR] && nested) begin
            code = RC_IGNORE;
        end else if (uc) begin
            if (blocked) begin
                code = RC_DISABLED;
            end else if (!mc_enable || nested) begin
                code = RC_RESET;
            end else begin
                code       = RC_LOGGED;
                st_we      = 1'b1;
                am_we      = 1'b1;
                gs_we      = 1'b1;
                new_status = inj_status;
                new_status[ST_OVER] = inj_status[ST_OVER] | old_val;
            end
        end else if (!old_val || !old_status[ST_UC]) begin
            code       = RC_LOGGED;
            st_we      = 1'b1;
            am_we      = 1'b1;
            new_status = inj_status;
            new_status[ST_OVER] = inj_status[ST_OVER] | old_val;
        end else begin
            code  = RC_LOGGED;
            st_we = 1'b1;
            new_status[ST_OVER] = 1'b1;
        end
    end
endmodule

// File: rtl/mcb_bank_file.sv
// Storage for NBANK banks of control/status/address/misc words.
// A log write has priority over a register-port write to the same bank.
// Assumes the caller only raises a write enable for an in-range bank.
module mcb_bank_file
    import mcb_pkg::*;
#(
    parameter  int NBANK = 4,
    localparam int BSW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rw_en,
    input  logic [BSW-1:0]          rw_bank,
    input  logic [1:0]              rw_sel,
    input  logic [XLEN-1:0]         rw_data,
    input  logic                    lg_st_we,
    input  logic                    lg_am_we,
    input  logic [BSW-1:0]          lg_bank,
    input  logic [XLEN-1:0]         lg_status,
    input  logic [XLEN-1:0]         lg_addr,
    input  logic [XLEN-1:0]         lg_misc,
    output mcb_bank_t [NBANK-1:0]   banks
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        mcb_bank_t q;

        // Per-bank register update: reset, log write, or port write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q.ctl    <= '1;
                q.status <= '0;
                q.addr   <= '0;
                q.misc   <= '0;
            end else if (lg_st_we && (lg_bank == BSW'(b))) begin
                q.status <= lg_status;
                if (lg_am_we) begin
                    q.addr <= lg_addr;
                    q.misc <= lg_misc;
                end
            end else if (rw_en && (rw_bank == BSW'(b))) begin
                case (rw_sel)
                    2'd0:    q.ctl    <= rw_data;
                    2'd1:    q.status <= rw_data;
                    2'd2:    q.addr   <= rw_data;
                    default: q.misc   <= rw_data;
                endcase
            end
        end

        assign banks[b] = q;
    end
endmodule

// File: rtl/mcb_logger.sv
// Machine-check bank error logger top.
// Holds the global words, decodes the indexed register port, judges
// each error report and registers the result code and event pulses.
// Assumes NBANK is between 1 and 255 and at most one report per cycle.
module mcb_logger
    import mcb_pkg::*;
#(
    parameter  int NBANK = 4,
    localparam int IW    = $clog2(4 * NBANK + 4),
    localparam int BSW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_enable,
    input  logic            inj_valid,
    input  logic [7:0]      inj_bank,
    input  logic [63:0]     inj_status,
    input  logic [63:0]     inj_gstatus,
    input  logic [63:0]     inj_addr,
    input  logic [63:0]     inj_misc,
    input  logic            inj_force,
    input  logic [IW-1:0]   reg_idx,
    input  logic            reg_we,
    input  logic [63:0]     reg_wdata,
    output logic [63:0]     reg_rdata,
    output logic            res_valid,
    output logic [2:0]      res_code,
    output logic            mc_irq,
    output logic            reset_req
);
    localparam logic [XLEN-1:0] CAP_RST = XLEN'(NBANK) | (XLEN'(1) << CAP_CTLP);

    logic [XLEN-1:0]        cap_q, gctl_q, gst_q;
    mcb_bank_t [NBANK-1:0]  banks;
    mcb_bank_t              old_bank;
    logic                   in_rng, wr_ok, rd_is_bank;
    logic [IW-1:0]          idx_off;
    logic [IW-3:0]          rbank_raw;
    logic [BSW-1:0]         rbank;
    mcb_rc_e                code;
    logic                   st_we, am_we, gs_we;
    logic [XLEN-1:0]        new_status;

    assign in_rng     = int'(inj_bank) < NBANK;
    assign old_bank   = in_rng ? banks[BSW'(inj_bank)] : '0;
    assign wr_ok      = reg_we && !inj_valid;
    assign idx_off    = reg_idx - IW'(4);
    assign rbank_raw  = idx_off[IW-1:2];
    assign rbank      = BSW'(rbank_raw);
    assign rd_is_bank = (reg_idx >= IW'(4)) && (int'(rbank_raw) < NBANK);

    mcb_judge u_judge (
        .req        (inj_valid),
        .bank_ok    (in_rng),
        .inj_bank   (inj_bank),
        .inj_status (inj_status),
        .inj_force  (inj_force),
        .mc_enable  (mc_enable),
        .cap        (cap_q),
        .gctl       (gctl_q),
        .gst        (gst_q),
        .old_ctl    (old_bank.ctl),
        .old_status (old_bank.status),
        .code       (code),
        .st_we      (st_we),
        .am_we      (am_we),
        .gs_we      (gs_we),
        .new_status (new_status)
    );

    mcb_bank_file #(.NBANK(NBANK)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .rw_en     (wr_ok && rd_is_bank),
        .rw_bank   (rbank),
        .rw_sel    (idx_off[1:0]),
        .rw_data   (reg_wdata),
        .lg_st_we  (st_we),
        .lg_am_we  (am_we),
        .lg_bank   (BSW'(inj_bank)),
        .lg_status (new_status),
        .lg_addr   (inj_addr),
        .lg_misc   (inj_misc),
        .banks     (banks)
    );

    // Global words: reset, log update of global status, port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= CAP_RST;
            gctl_q <= '1;
            gst_q  <= '0;
        end else begin
            if (gs_we) begin
                gst_q <= inj_gstatus;
            end else if (wr_ok && (reg_idx == IW'(2))) begin
                gst_q <= reg_wdata;
            end
            if (wr_ok && (reg_idx == IW'(0))) cap_q  <= reg_wdata;
            if (wr_ok && (reg_idx == IW'(1))) gctl_q <= reg_wdata;
        end
    end

    // Result register: one-cycle code and event pulses per report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= RC_NONE;
            mc_irq    <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            res_valid <= inj_valid;
            res_code  <= code;
            mc_irq    <= gs_we;
            reset_req <= (code == RC_RESET);
        end
    end

    // Register read multiplexer over the index map.
    always_comb begin
        reg_rdata = '0;
        if (reg_idx == IW'(0)) begin
            reg_rdata = cap_q;
        end else if (reg_idx == IW'(1)) begin
            reg_rdata = gctl_q;
        end else if (reg_idx == IW'(2)) begin
            reg_rdata = gst_q;
        end else if (rd_is_bank) begin
            case (idx_off[1:0])
                2'd0:    reg_rdata = banks[rbank].ctl;
                2'd1:    reg_rdata = banks[rbank].status;
                2'd2:    reg_rdata = banks[rbank].addr;
                default: reg_rdata = banks[rbank].misc;
            endcase
        end
    end
endmodule

// File: rtl/mcb_logger_chk.sv
// Property checker for mcb_logger, attached by bind.
// Observes the report strobe, the result outputs and the global status.
module mcb_logger_chk
    import mcb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        inj_valid,
    input logic [63:0] inj_gstatus,
    input logic        res_valid,
    input logic [2:0]  res_code,
    input logic        mc_irq,
    input logic        reset_req,
    input logic [63:0] gst
);
    // R10: a result follows each report by exactly one cycle.
    a_r10_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(inj_valid)));

    // R10: interrupt and reset request never fire together.
    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(mc_irq && reset_req));

    // R6: a reset request always carries the escalation code.
    a_r6_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (res_valid && res_code == RC_RESET));

    // R7: an interrupt carries the logged code and the new global status.
    a_r7_irq_loads_gstatus: assert property (@(posedge clk) disable iff (!rst_n)
        mc_irq |-> (res_valid && res_code == RC_LOGGED && gst == $past(inj_gstatus)));

    // R3: a rejected report raises no event.
    a_r3_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == RC_REJECT) |-> (!mc_irq && !reset_req));

    // R4: non-logging outcomes leave the global status alone.
    a_r4_gstatus_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_valid && res_code != RC_LOGGED) |-> (gst == $past(gst)));
endmodule

bind mcb_logger mcb_logger_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inj_valid   (inj_valid),
    .inj_gstatus (inj_gstatus),
    .res_valid   (res_valid),
    .res_code    (res_code),
    .mc_irq      (mc_irq),
    .reset_req   (reset_req),
    .gst         (gst_q)
);

// File: tb/mcb_logger_test.sv
`timescale 1ns/1ps
// Bench for mcb_logger: behavioural model updated each rising edge,
// compared with the design on each falling edge.
module mcb_logger_test;
    localparam int NB = 4;
    localparam int IW = 5;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] S_UC   = 64'hA000_0000_0000_0011;
    localparam logic [63:0] S_UCAR = 64'hA080_0000_0000_0022;
    localparam logic [63:0] S_CE   = 64'h8000_0000_0000_0042;

    logic clk = 0, rst_n = 0, mc_enable = 1, inj_valid = 0, inj_force = 0, reg_we = 0;
    logic [7:0] inj_bank = 0;
    logic [63:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0, reg_wdata = 0;
    logic [IW-1:0] reg_idx = 0;
    logic [63:0] reg_rdata;
    logic res_valid, mc_irq, reset_req;
    logic [2:0] res_code;

    always #2 clk = ~clk;

    mcb_logger #(.NBANK(NB)) uut (
        .clk(clk), .rst_n(rst_n), .mc_enable(mc_enable), .inj_valid(inj_valid),
        .inj_bank(inj_bank), .inj_status(inj_status), .inj_gstatus(inj_gstatus),
        .inj_addr(inj_addr), .inj_misc(inj_misc), .inj_force(inj_force),
        .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .res_valid(res_valid), .res_code(res_code), .mc_irq(mc_irq), .reset_req(reset_req));

    int tests = 0, fails = 0, cyc = 0;
    bit started = 0, done = 0;
    string cur_tag = "R1", exp_tag = "R1";
    logic [63:0] m_cap, m_gctl, m_gst;
    logic [63:0] m_ctl[NB], m_st[NB], m_ad[NB], m_mi[NB];
    bit e_valid, e_irq, e_rst;
    int e_code;

    function automatic logic [63:0] mread(int idx);
        if (idx == 0) return m_cap;
        if (idx == 1) return m_gctl;
        if (idx == 2) return m_gst;
        if (idx < 4 || idx >= 4 + 4 * NB) return 64'd0;
        case ((idx - 4) % 4)
            0: return m_ctl[(idx - 4) / 4];
            1: return m_st[(idx - 4) / 4];
            2: return m_ad[(idx - 4) / 4];
            default: return m_mi[(idx - 4) / 4];
        endcase
    endfunction

    task automatic mwrite(int idx, logic [63:0] d);
        if (idx == 0) m_cap = d;
        else if (idx == 1) m_gctl = d;
        else if (idx == 2) m_gst = d;
        else if (idx >= 4 && idx < 4 + 4 * NB) begin
            case ((idx - 4) % 4)
                0: m_ctl[(idx - 4) / 4] = d;
                1: m_st[(idx - 4) / 4] = d;
                2: m_ad[(idx - 4) / 4] = d;
                default: m_mi[(idx - 4) / 4] = d;
            endcase
        end
    endtask

    task automatic minject();
        int b = int'(inj_bank);
        logic [63:0] ns;
        e_valid = 1;
        if (m_cap == 0 || b >= int'(m_cap[7:0]) || b >= NB || !inj_status[63]) e_code = 1;
        else if (!inj_force && !inj_status[55] && m_gst[2]) e_code = 2;
        else if (inj_status[61]) begin
            if ((m_cap[8] && m_gctl != ONES) || m_ctl[b] != ONES) e_code = 3;
            else if (!mc_enable || m_gst[2]) begin e_code = 5; e_rst = 1; end
            else begin
                ns = inj_status;
                if (m_st[b][63]) ns[62] = 1'b1;
                m_ad[b] = inj_addr; m_mi[b] = inj_misc; m_gst = inj_gstatus; m_st[b] = ns;
                e_code = 4; e_irq = 1;
            end
        end else if (!m_st[b][63] || !m_st[b][61]) begin
            ns = inj_status;
            if (m_st[b][63]) ns[62] = 1'b1;
            m_ad[b] = inj_addr; m_mi[b] = inj_misc; m_st[b] = ns; e_code = 4;
        end else begin
            m_st[b][62] = 1'b1; e_code = 4;
        end
    endtask

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        started = 1; exp_tag = cur_tag;
        e_valid = 0; e_code = 0; e_irq = 0; e_rst = 0;
        if (!rst_n) begin
            m_cap = 64'h104; m_gctl = ONES; m_gst = 0;
            for (int b = 0; b < NB; b++) begin
                m_ctl[b] = ONES; m_st[b] = 0; m_ad[b] = 0; m_mi[b] = 0;
            end
        end else if (inj_valid) minject();
        else if (reg_we) mwrite(int'(reg_idx), reg_wdata);
    end

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(exp_tag, "res_valid", 64'(res_valid), 64'(e_valid));
            chk(exp_tag, "mc_irq", 64'(mc_irq), 64'(e_irq));
            chk(exp_tag, "reset_req", 64'(reset_req), 64'(e_rst));
            if (e_valid) chk(exp_tag, "res_code", 64'(res_code), 64'(e_code));
            chk(cur_tag, "reg_rdata", reg_rdata, mread(int'(reg_idx)));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1; fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic peek(string tag, int idx);
        step(); cur_tag = tag; reg_idx = IW'(idx);
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 32; i++) peek(tag, i);
    endtask

    task automatic wr(string tag, int idx, logic [63:0] d);
        step(); cur_tag = tag; reg_idx = IW'(idx); reg_wdata = d; reg_we = 1;
        step(); reg_we = 0;
    endtask

    task automatic inj(string tag, int bank, logic [63:0] st, logic [63:0] gs,
                       logic [63:0] ad, bit frc);
        step(); cur_tag = tag;
        inj_bank = 8'(bank); inj_status = st; inj_gstatus = gs; inj_addr = ad;
        inj_misc = ad ^ 64'h5A5A; inj_force = frc; inj_valid = 1;
        reg_idx = IW'(4 + 4 * (bank % NB) + 1);
        step(); inj_valid = 0;
        reg_idx = IW'(4 + 4 * (bank % NB) + 2);
        step(); reg_idx = IW'(2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        sweep("R1");
        // R2: map, write visibility, unmapped index
        wr("R2", 10, 64'h1234); peek("R2", 10);
        wr("R2", 25, 64'hDEAD); peek("R2", 25);
        wr("R2", 3, 64'hBEEF); peek("R2", 3);
        wr("R2", 19, 64'h77); peek("R2", 19); wr("R2", 19, 0);
        // R7: uncorrected log with nesting status
        inj("R7", 0, S_UC, 64'h5, 64'h1000, 0);
        // R6: nested uncorrected with action required escalates
        inj("R6", 1, S_UCAR, 64'h5, 64'h2000, 0);
        wr("R6", 2, 0);
        mc_enable = 0;
        inj("R6", 1, S_UC, 64'h1, 64'h2100, 0);
        mc_enable = 1;
        // R4: ignore while nested, unless unconditional
        wr("R4", 2, 64'h4);
        inj("R4", 3, S_CE, 64'h1, 64'h3000, 0);
        inj("R4", 2, S_UC, 64'h1, 64'h3100, 0);
        inj("R8", 3, S_CE, 64'h1, 64'h3200, 1);
        wr("R4", 2, 0);
        // R5: global and bank reporting disable
        wr("R5", 1, 0);
        inj("R5", 2, S_UC, 64'h1, 64'h4000, 0);
        wr("R5", 0, 64'h4);
        inj("R5", 2, S_UC, 64'h1, 64'h4100, 0);
        wr("R5", 0, 64'h104); wr("R5", 1, ONES);
        wr("R5", 12, 0);
        inj("R5", 2, S_UC, 64'h1, 64'h4200, 0);
        wr("R5", 12, ONES);
        // R7: overflow on a second uncorrected log
        inj("R7", 0, S_UC, 64'h1, 64'h5000, 0);
        // R8: corrected overwrite with overflow
        inj("R8", 3, S_CE, 64'h1, 64'h6000, 0);
        inj("R8", 1, S_CE, 64'h1, 64'h6100, 0);
        // R9: corrected onto a valid uncorrected record
        inj("R9", 0, S_CE, 64'h1, 64'h7000, 0);
        peek("R9", 6); peek("R9", 7);
        // R3: rejection cases
        inj("R3", 1, 64'h2000_0000_0000_0001, 64'h1, 64'h8000, 0);
        inj("R3", 4, S_CE, 64'h1, 64'h8100, 0);
        inj("R3", 200, S_CE, 64'h1, 64'h8150, 0);
        wr("R3", 0, 64'h102);
        inj("R3", 3, S_CE, 64'h1, 64'h8200, 0);
        wr("R3", 0, 0);
        inj("R3", 0, S_CE, 64'h1, 64'h8300, 0);
        wr("R3", 0, 64'h104);
        // R10: concurrent write dropped, back-to-back reports
        step(); cur_tag = "R10";
        inj_bank = 1; inj_status = S_CE; inj_gstatus = 0; inj_addr = 64'h9000;
        inj_misc = 1; inj_force = 0; inj_valid = 1;
        reg_idx = IW'(2); reg_we = 1; reg_wdata = 64'h7;
        step(); reg_we = 0;
        inj_bank = 2; inj_status = S_UC; inj_gstatus = 64'h1; inj_addr = 64'h9100;
        step(); inj_bank = 3; inj_status = S_CE; inj_addr = 64'h9200;
        step(); inj_valid = 0;
        step();
        sweep("R10");
        repeat (2) step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule